// File: doc/BRIEF.md
# Interrupt Status Unit with Deferred Completion

This unit holds the interrupt and status state of a SCSI-style host adapter. It keeps a status register, an interrupt-cause register, a sequence-step register, a FIFO-flags register and a transfer count. It drives one level interrupt line. The command decoder, the data path and the bus logic sit outside the block. They reach it only as single-cycle event pulses: a generic interrupt raise with a cause code, a command-complete carrying a status byte, a selection that found no target, and a transfer-done mark. The host reads the registers through a small read port. Reading the cause register acknowledges the interrupt.

The host may not yet have acknowledged an earlier interrupt when a command-complete arrives. In that case the unit parks the status byte in a one-deep slot and changes nothing else. When the host later reads the cause register, the interrupt line drops for one cycle. The parked completion is then reported automatically on the next cycle.

A four-state machine sequences this behaviour:
- `ST_IDLE`: no interrupt pending.
- `ST_PEND`: an interrupt is pending and the slot is empty.
- `ST_HELD`: an interrupt is pending and a completion is parked.
- `ST_REPLAY`: the single cycle after an acknowledge in which the parked completion is reported.

The transitions are:
- raise, no-target or completion from `ST_IDLE` goes to `ST_PEND`.
- completion in `ST_PEND` goes to `ST_HELD`.
- acknowledge in `ST_PEND` with no completion returns to `ST_IDLE`.
- acknowledge in `ST_HELD`, or an acknowledge together with a completion, goes to `ST_REPLAY`.
- `ST_REPLAY` goes to `ST_PEND`, or to `ST_HELD` when a new completion arrives in that cycle.

Top module: `ist_top`

## Requirements
- R1: The reset is synchronous and active high. After it, irq is 0 and status, cause, sequence step, FIFO flags, transfer count and final_status all read 0.
- R2: A raise pulse in `ST_IDLE` writes raise_cause into the cause register and sets irq, with status bit 7 (INT) following irq. A raise while an interrupt is already pending only overwrites the cause register, and irq stays high without a new edge.
- R3: The read port is combinational and returns, by rd_addr: 0 status, 1 cause, 2 sequence step, 3 FIFO flags. Status layout: bit 7 INT, bit 4 terminal count (TC), bits 2:0 phase. A cause read returns the value held before the read.
- R4: A read at address 1 acknowledges the interrupt. On the next cycle the cause register is 0, TC is 0, the sequence step equals SEQ_DONE (default 4) and irq is 0.
- R5: A completion in `ST_IDLE` is reported at once. The report sets status to 0x93 (INT, TC, phase 3'b011). It sets cause to 0x10 (bus service), the sequence step, FIFO flags and transfer count to 0, and final_status to the status byte.
- R6: A completion while irq is high leaves every register and irq unchanged. Its byte is parked, and a later completion before the acknowledge overwrites the parked byte.
- R7: An acknowledge in `ST_HELD` gives one cycle with irq 0, cause 0 and sequence step SEQ_DONE. On the following cycle the parked byte is reported exactly as in R5.
- R8: A completion that arrives in the same cycle as an acknowledge, or during `ST_REPLAY`, is parked rather than lost. It is reported after the next acknowledge.
- R9: A no-target pulse clears status bits 6:0, sets cause to 0x20 (disconnect) and the sequence step to 0, and sets irq.
- R10: Within one cycle the priority is acknowledge, then completion, then no-target, then raise. A raise or no-target that loses, or that arrives during `ST_REPLAY`, is dropped.
- R11: xfer_done sets TC, tc_load loads the transfer count and flags_load loads the FIFO flags register. Any write by a report, no-target or acknowledge to the same field takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 8 | Read data, combinational |
| raise_valid | input | 1 | Generic interrupt request |
| raise_cause | input | 8 | Cause code written by a raise |
| cmpl_valid | input | 1 | Command-complete event |
| cmpl_byte | input | 8 | Status byte of the completion |
| nodev_valid | input | 1 | Selection found no target |
| xfer_done | input | 1 | Sets the terminal-count bit |
| tc_load | input | 1 | Load the transfer count |
| tc_value | input | TCW | Transfer count to load |
| flags_load | input | 1 | Load the FIFO flags register |
| flags_value | input | 8 | FIFO flags to load |
| irq | output | 1 | Level interrupt |
| tc_count | output | TCW | Current transfer count |
| final_status | output | 8 | Last reported completion byte |

## Verification
Completions are driven in three situations: with no interrupt pending, while an interrupt is pending, and in the very cycle of an acknowledge or a replay. These separate an immediate report from a parked one, and show whether a late byte survives. Two completions are parked back to back, which shows that the slot keeps the newest byte. Raise and no-target pulses are given alone, repeated, together with other events, and inside the replay cycle. This shows which cause survives, and that a dropped request leaves the line and the registers as they were.

// File: rtl/ist_pkg.sv
package ist_pkg;
    localparam int BYTE_W = 8;

    // machine states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PEND   = 2'd1,
        ST_HELD   = 2'd2,
        ST_REPLAY = 2'd3
    } ist_state_e;

    // register action chosen for one cycle
    typedef enum logic [2:0] {
        ACT_NONE   = 3'd0,
        ACT_ACK    = 3'd1,
        ACT_REPORT = 3'd2,
        ACT_NODEV  = 3'd3,
        ACT_RAISE  = 3'd4
    } ist_act_e;

    // one-hot cause codes
    localparam logic [BYTE_W-1:0] CAUSE_FC  = 8'h08;
    localparam logic [BYTE_W-1:0] CAUSE_BS  = 8'h10;
    localparam logic [BYTE_W-1:0] CAUSE_DC  = 8'h20;
    localparam logic [BYTE_W-1:0] CAUSE_RST = 8'h80;

    // status layout (bit 7 INT is derived from the machine state)
    localparam int          STAT_TC_BIT = 4;
    localparam logic [2:0]  PHASE_ST    = 3'b011;

    // read addresses
    localparam logic [1:0] ADDR_STAT  = 2'd0;
    localparam logic [1:0] ADDR_CAUSE = 2'd1;
    localparam logic [1:0] ADDR_SEQ   = 2'd2;
    localparam logic [1:0] ADDR_FLAGS = 2'd3;
endpackage

// File: rtl/ist_fsm.sv
module ist_fsm
    import ist_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ack,
    input  logic       cmpl_valid,
    input  logic       nodev_valid,
    input  logic       raise_valid,
    output ist_state_e state_q,
    output ist_act_e   act,
    output logic       slot_load,
    output logic       from_slot
);
    ist_state_e state_n;

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE, ST_PEND, ST_HELD: begin
                if (ack) begin
                    state_n = (cmpl_valid || state_q == ST_HELD) ? ST_REPLAY : ST_IDLE;
                end else if (cmpl_valid) begin
                    state_n = (state_q == ST_IDLE) ? ST_PEND : ST_HELD;
                end else if (nodev_valid || raise_valid) begin
                    state_n = (state_q == ST_IDLE) ? ST_PEND : state_q;
                end
            end
            ST_REPLAY: begin
                state_n = cmpl_valid ? ST_HELD : ST_PEND;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // outputs
    always_comb begin
        act       = ACT_NONE;
        slot_load = 1'b0;
        from_slot = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_PEND, ST_HELD: begin
                if (ack) begin
                    act       = ACT_ACK;
                    slot_load = cmpl_valid;
                end else if (cmpl_valid) begin
                    if (state_q == ST_IDLE) begin
                        act = ACT_REPORT;
                    end else begin
                        slot_load = 1'b1;
                    end
                end else if (nodev_valid) begin
                    act = ACT_NODEV;
                end else if (raise_valid) begin
                    act = ACT_RAISE;
                end
            end
            ST_REPLAY: begin
                act       = ACT_REPORT;
                from_slot = 1'b1;
                slot_load = cmpl_valid;
            end
            default: act = ACT_NONE;
        endcase
    end
endmodule

// File: rtl/ist_slot.sv
module ist_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end
endmodule

// File: rtl/ist_regs.sv
module ist_regs
    import ist_pkg::*;
#(
    parameter int                TCW      = 24,
    parameter logic [BYTE_W-1:0] SEQ_DONE = 8'h04
) (
    input  logic              clk,
    input  logic              rst,
    input  ist_act_e          act,
    input  logic [BYTE_W-1:0] report_byte,
    input  logic [BYTE_W-1:0] raise_cause,
    input  logic              xfer_done,
    input  logic              tc_load,
    input  logic [TCW-1:0]    tc_value,
    input  logic              flags_load,
    input  logic [BYTE_W-1:0] flags_value,
    output logic [6:0]        stat_q,
    output logic [BYTE_W-1:0] cause_q,
    output logic [BYTE_W-1:0] seq_q,
    output logic [BYTE_W-1:0] flags_q,
    output logic [TCW-1:0]    tc_q,
    output logic [BYTE_W-1:0] fin_q
);
    localparam logic [6:0] STAT_REPORT = 7'(PHASE_ST) | (7'd1 << STAT_TC_BIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q  <= '0;
            cause_q <= '0;
            seq_q   <= '0;
            flags_q <= '0;
            tc_q    <= '0;
            fin_q   <= '0;
        end else begin
            // low-priority field updates, overridden by the action below
            if (xfer_done)  stat_q[STAT_TC_BIT] <= 1'b1;
            if (tc_load)    tc_q    <= tc_value;
            if (flags_load) flags_q <= flags_value;
            unique case (act)
                ACT_ACK: begin
                    cause_q             <= '0;
                    stat_q[STAT_TC_BIT] <= 1'b0;
                    seq_q               <= SEQ_DONE;
                end
                ACT_REPORT: begin
                    stat_q  <= STAT_REPORT;
                    cause_q <= CAUSE_BS;
                    seq_q   <= '0;
                    flags_q <= '0;
                    tc_q    <= '0;
                    fin_q   <= report_byte;
                end
                ACT_NODEV: begin
                    stat_q  <= '0;
                    cause_q <= CAUSE_DC;
                    seq_q   <= '0;
                end
                ACT_RAISE: begin
                    cause_q <= raise_cause;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ist_top.sv
module ist_top
    import ist_pkg::*;
#(
    parameter int          TCW      = 24,
    parameter logic [7:0]  SEQ_DONE = 8'h04
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rd_en,
    input  logic [1:0]     rd_addr,
    output logic [7:0]     rd_data,
    input  logic           raise_valid,
    input  logic [7:0]     raise_cause,
    input  logic           cmpl_valid,
    input  logic [7:0]     cmpl_byte,
    input  logic           nodev_valid,
    input  logic           xfer_done,
    input  logic           tc_load,
    input  logic [TCW-1:0] tc_value,
    input  logic           flags_load,
    input  logic [7:0]     flags_value,
    output logic           irq,
    output logic [TCW-1:0] tc_count,
    output logic [7:0]     final_status
);
    logic       ack;
    ist_state_e st_q;
    ist_act_e   act;
    logic       slot_load;
    logic       from_slot;
    logic [7:0] slot_q;
    logic [7:0] report_byte;
    logic [6:0] stat_q;
    logic [7:0] cause_q;
    logic [7:0] seq_q;
    logic [7:0] flags_q;

    assign ack = rd_en && (rd_addr == ADDR_CAUSE);

    ist_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ack         (ack),
        .cmpl_valid  (cmpl_valid),
        .nodev_valid (nodev_valid),
        .raise_valid (raise_valid),
        .state_q     (st_q),
        .act         (act),
        .slot_load   (slot_load),
        .from_slot   (from_slot)
    );

    ist_slot #(.W(BYTE_W)) u_slot (
        .clk  (clk),
        .rst  (rst),
        .load (slot_load),
        .din  (cmpl_byte),
        .q    (slot_q)
    );

    assign report_byte = from_slot ? slot_q : cmpl_byte;

    ist_regs #(.TCW(TCW), .SEQ_DONE(SEQ_DONE)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .act         (act),
        .report_byte (report_byte),
        .raise_cause (raise_cause),
        .xfer_done   (xfer_done),
        .tc_load     (tc_load),
        .tc_value    (tc_value),
        .flags_load  (flags_load),
        .flags_value (flags_value),
        .stat_q      (stat_q),
        .cause_q     (cause_q),
        .seq_q       (seq_q),
        .flags_q     (flags_q),
        .tc_q        (tc_count),
        .fin_q       (final_status)
    );

    assign irq = (st_q == ST_PEND) || (st_q == ST_HELD);

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (rd_addr)
                ADDR_STAT:  rd_data = {irq, stat_q};
                ADDR_CAUSE: rd_data = cause_q;
                ADDR_SEQ:   rd_data = seq_q;
                ADDR_FLAGS: rd_data = flags_q;
                default:    rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/ist_chk.sv
module ist_chk
    import ist_pkg::*;
#(
    parameter int         TCW      = 24,
    parameter logic [7:0] SEQ_DONE = 8'h04
) (
    input logic           clk,
    input logic           rst,
    input logic           rd_en,
    input logic [1:0]     rd_addr,
    input logic           raise_valid,
    input logic           cmpl_valid,
    input logic [7:0]     cmpl_byte,
    input logic           nodev_valid,
    input logic           xfer_done,
    input logic           irq,
    input logic [1:0]     st,
    input logic [6:0]     stat,
    input logic [7:0]     cause,
    input logic [7:0]     seq,
    input logic [TCW-1:0] tc,
    input logic [7:0]     fin
);
    logic ack;
    assign ack = rd_en && (rd_addr == ADDR_CAUSE);

    // R4
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack && st != ST_REPLAY) |=> (cause == 8'h00 && !irq && seq == SEQ_DONE && !stat[STAT_TC_BIT]));

    // R5
    a_r5_direct_report: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && cmpl_valid && !ack) |=>
        (irq && cause == CAUSE_BS && seq == 8'h00 && tc == '0 && fin == $past(cmpl_byte)));

    // R6
    a_r6_defer_stable: assert property (@(posedge clk) disable iff (rst)
        (irq && cmpl_valid && !ack && !xfer_done) |=>
        (irq && $stable(cause) && $stable(stat) && $stable(fin)));

    // R7
    a_r7_replay: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HELD && ack) |=> (!irq ##1 (irq && cause == CAUSE_BS)));

    // R9
    a_r9_nodev: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && nodev_valid && !cmpl_valid && !ack) |=>
        (irq && cause == CAUSE_DC && seq == 8'h00 && stat == 7'h00));

    // R2
    a_r2_raise_keeps_line: assert property (@(posedge clk) disable iff (rst)
        (irq && raise_valid && !ack) |=> irq);
endmodule

bind ist_top ist_chk #(.TCW(TCW), .SEQ_DONE(SEQ_DONE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .raise_valid (raise_valid),
    .cmpl_valid  (cmpl_valid),
    .cmpl_byte   (cmpl_byte),
    .nodev_valid (nodev_valid),
    .xfer_done   (xfer_done),
    .irq         (irq),
    .st          (st_q),
    .stat        (stat_q),
    .cause       (cause_q),
    .seq         (seq_q),
    .tc          (tc_count),
    .fin         (final_status)
);

// File: tb/ist_top_tb.sv
module ist_top_tb;
    localparam int TCW = 24;

    logic           clk = 1'b0;
    logic           rst;
    logic           rd_en;
    logic [1:0]     rd_addr;
    logic [7:0]     rd_data;
    logic           raise_valid;
    logic [7:0]     raise_cause;
    logic           cmpl_valid;
    logic [7:0]     cmpl_byte;
    logic           nodev_valid;
    logic           xfer_done;
    logic           tc_load;
    logic [TCW-1:0] tc_value;
    logic           flags_load;
    logic [7:0]     flags_value;
    logic           irq;
    logic [TCW-1:0] tc_count;
    logic [7:0]     final_status;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ist_top #(.TCW(TCW)) u_dut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .raise_valid(raise_valid), .raise_cause(raise_cause),
        .cmpl_valid(cmpl_valid), .cmpl_byte(cmpl_byte), .nodev_valid(nodev_valid),
        .xfer_done(xfer_done), .tc_load(tc_load), .tc_value(tc_value),
        .flags_load(flags_load), .flags_value(flags_value),
        .irq(irq), .tc_count(tc_count), .final_status(final_status)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic idle_inputs();
        rd_en = 0; rd_addr = 0; raise_valid = 0; raise_cause = 0;
        cmpl_valid = 0; cmpl_byte = 0; nodev_valid = 0; xfer_done = 0;
        tc_load = 0; tc_value = 0; flags_load = 0; flags_value = 0;
    endtask

    // one clock: inputs were set after a falling edge, consumed at the rising edge
    task automatic tick();
        @(negedge clk);
        idle_inputs();
    endtask

    // read a register; a read of address 1 acknowledges
    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_en = 1; rd_addr = a;
        #1 d = rd_data;
        tick();
    endtask

    task automatic do_raise(input logic [7:0] c);
        raise_valid = 1; raise_cause = c; tick();
    endtask

    task automatic do_cmpl(input logic [7:0] b);
        cmpl_valid = 1; cmpl_byte = b; tick();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 irq", irq, 0);
        rd(0, d); check("R1 status", d, 8'h00);
        rd(2, d); check("R1 seq", d, 8'h00);
        rd(3, d); check("R1 flags", d, 8'h00);
        check("R1 tc", tc_count, 0);
        check("R1 final", final_status, 0);
        rd(1, d); check("R1 cause", d, 8'h00);
        rd(2, d); check("R4 seq after ack", d, 8'h04);
    endtask

    task automatic t_raise();
        logic [7:0] d;
        do_raise(8'h08);
        check("R2 irq set", irq, 1);
        rd(0, d); check("R2 status INT", d, 8'h80);
        do_raise(8'h80);
        check("R2 irq held", irq, 1);
        rd(1, d); check("R3 cause returns prior", d, 8'h80);
        check("R4 irq dropped", irq, 0);
        rd(1, d); check("R4 cause cleared", d, 8'h00);
    endtask

    task automatic t_complete();
        logic [7:0] d;
        tc_load = 1; tc_value = 24'h123456; flags_load = 1; flags_value = 8'h05; xfer_done = 1;
        tick();
        check("R11 tc loaded", tc_count, 24'h123456);
        rd(0, d); check("R11 TC set", d, 8'h10);
        rd(3, d); check("R11 flags loaded", d, 8'h05);
        do_cmpl(8'h02);
        check("R5 irq", irq, 1);
        rd(0, d); check("R5 status", d, 8'h93);
        rd(2, d); check("R5 seq", d, 8'h00);
        rd(3, d); check("R5 flags", d, 8'h00);
        check("R5 tc", tc_count, 0);
        check("R5 final", final_status, 8'h02);
        rd(1, d); check("R5 cause", d, 8'h10);
        rd(0, d); check("R4 TC cleared", d, 8'h03);
        rd(2, d); check("R4 seq done", d, 8'h04);
    endtask

    task automatic t_defer();
        logic [7:0] d;
        do_raise(8'h08);
        do_cmpl(8'h22);
        check("R6 irq held", irq, 1);
        rd(0, d); check("R6 status unchanged", d, 8'h83);
        check("R6 final unchanged", final_status, 8'h02);
        do_cmpl(8'h44);
        rd(1, d); check("R6 cause unchanged", d, 8'h08);
        check("R7 irq gap", irq, 0);
        rd(2, d); check("R7 seq in gap", d, 8'h04);
        check("R7 irq back", irq, 1);
        check("R7 replay byte newest", final_status, 8'h44);
        rd(0, d); check("R7 status", d, 8'h93);
        rd(1, d); check("R7 cause", d, 8'h10);
        tick();
        check("R7 idle after", irq, 0);
    endtask

    task automatic t_late_cmpl();
        logic [7:0] d;
        do_raise(8'h08);
        do_cmpl(8'hA1);
        // acknowledge with a completion in the same cycle
        rd_en = 1; rd_addr = 1; cmpl_valid = 1; cmpl_byte = 8'hB2;
        tick();
        check("R8 gap", irq, 0);
        do_cmpl(8'hC3);          // arrives during the replay cycle
        check("R8 replay uses ack-cycle byte", final_status, 8'hB2);
        check("R8 irq", irq, 1);
        rd(1, d); tick();
        check("R8 replay-cycle byte kept", final_status, 8'hC3);
        rd(1, d); tick();
        check("R8 settled", irq, 0);
    endtask

    task automatic t_nodev();
        logic [7:0] d;
        xfer_done = 1; tick();
        nodev_valid = 1; tick();
        check("R9 irq", irq, 1);
        rd(0, d); check("R9 status", d, 8'h80);
        rd(2, d); check("R9 seq", d, 8'h00);
        rd(1, d); check("R9 cause", d, 8'h20);
    endtask

    task automatic t_priority();
        logic [7:0] d;
        rd_en = 1; rd_addr = 1; raise_valid = 1; raise_cause = 8'h80;
        tick();
        check("R10 raise lost to ack", irq, 0);
        cmpl_valid = 1; cmpl_byte = 8'h11; nodev_valid = 1; raise_valid = 1; raise_cause = 8'h08;
        tick();
        rd(1, d); check("R10 cmpl beats nodev", d, 8'h10);
        nodev_valid = 1; raise_valid = 1; raise_cause = 8'h08;
        tick();
        rd(1, d); check("R10 nodev beats raise", d, 8'h20);
        do_raise(8'h08);
        do_cmpl(8'h55);
        rd(1, d);
        do_raise(8'h80);         // during replay: dropped
        rd(1, d); check("R10 raise in replay dropped", d, 8'h10);
        check("R10 final", final_status, 8'h55);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_raise();
        t_complete();
        t_defer();
        t_late_cmpl();
        t_nodev();
        t_priority();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule